// File: doc/BRIEF.md
# Lock-Aware Serial Audio Output Selector

This block chooses which serial audio bit stream appears on a receiver's data output pin. While the receive clock recovery reports lock, the output carries the demodulated receive data. While it reports unlock, the output carries an auxiliary serial input, so that a local source can be heard. Every move between the two sources passes through a run of muted frames. The change happens only on a frame-sync strobe, so the output never emits a partial sample.

Three control bits override the automatic choice. Force-mute holds the output at zero. Force-auxiliary selects the auxiliary stream whatever the lock state is. Force-error drives the error/status output high. The error/status output otherwise reports the inverse of the lock flag. The lock flag only counts as valid while the recovery loop is enabled. This holds even when the outgoing clock comes from a crystal.

The frame-sync and bit-clock strobes are one-cycle enables in the system clock domain. The frame-sync strobe always arrives together with the bit-clock strobe of the first bit of a frame.

Top module: `audio_out_selector`

## Requirements
- R1: When the effective lock has been high for longer than the mute interval, each bit loaded into `out_bit` equals `demod_bit` as sampled on that bit strobe.
- R2: When the effective lock has been low in steady state, each bit loaded into `out_bit` equals `aux_bit`.
- R3: When lock is seen at a frame start while the auxiliary source is active, the output is 0 for exactly MUTE_FRAMES whole frames. It then carries demodulated data if lock is still present at that frame start, and auxiliary data if it is not.
- R4: When lock is lost at a frame start while demodulated data is active, the output is 0 for exactly MUTE_FRAMES whole frames. It then carries auxiliary data if lock is still absent at that frame start.
- R5: The lock input, `force_aux` and `force_mute` are sampled only on cycles with `fs_stb`=1. A change in the middle of a frame does not alter the source of that frame's remaining bits.
- R6: With `force_aux`=1 at a frame start and `force_mute`=0, every bit of that frame equals `aux_bit`, whether the lock is high or low.
- R7: With `force_mute`=1 at a frame start, every bit of that frame is 0, whatever `force_aux` and the lock are.
- R8: `err_out` equals `force_err` OR NOT(effective lock), registered with one clock of latency.
- R9: The effective lock is `pll_on` AND `pll_lock`. With `pll_on`=0 the block behaves as unlocked even when `pll_lock`=1.
- R10: After reset, `out_bit`=0 and `err_out`=1. The output stays 0 on bit strobes until the first `fs_stb`, and the sequencer starts on the auxiliary source.
- R11: `out_bit` changes only on the clock edge of a cycle with `bclk_stb`=1. It holds its value on all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pll_on | input | 1 | Clock-recovery loop enabled |
| pll_lock | input | 1 | Clock-recovery lock flag |
| demod_bit | input | 1 | Demodulated receive data bit |
| aux_bit | input | 1 | Auxiliary serial input bit |
| fs_stb | input | 1 | Frame-start strobe, one cycle |
| bclk_stb | input | 1 | Bit strobe, one cycle per output bit |
| force_aux | input | 1 | Select the auxiliary input regardless of lock |
| force_mute | input | 1 | Hold the output at 0 |
| force_err | input | 1 | Drive the error/status output high |
| out_bit | output | 1 | Selected serial output bit |
| err_out | output | 1 | Error/status flag |

## Verification
`out_bit` is due one clock after the edge that carries `bclk_stb`. The value it takes is chosen by the source in force for the frame whose `fs_stb` coincides with, or precedes, that strobe. `err_out` is due one clock after any change of lock, `pll_on` or `force_err`. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands exactly one registered stage after its stimulus. On the idle half of every bit the bench flips both data inputs and confirms that `out_bit` holds. A reference model advances its source state only at frame starts and yields the expected bit of each strobe arithmetically.

// File: rtl/audsel_pkg.sv
// Package: shared encodings for the lock-aware audio output selector.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package audsel_pkg;

    // Sequencer position for automatic lock-driven selection
    typedef enum logic [1:0] {
        SEQ_AUX  = 2'd0,
        SEQ_MUTE = 2'd1,
        SEQ_DEM  = 2'd2
    } seq_t;

    // Route actually applied to the output for the current frame
    typedef enum logic [1:0] {
        RT_MUTE = 2'd0,
        RT_AUX  = 2'd1,
        RT_DEM  = 2'd2
    } route_t;

endpackage

// File: rtl/lock_seq.sv
// Module: lock_seq
// Tracks the effective lock at frame boundaries and walks the sequence
// auxiliary -> muted -> demodulated (and back). The muted stay lasts
// MUTE_FRAMES frames. At its end the source follows the lock seen then.
// Assumes fs_stb is a single-cycle strobe in the clk domain.
module lock_seq
    import audsel_pkg::*;
#(
    parameter int MUTE_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_eff,
    input  logic fs_stb,
    output seq_t state_d,
    output seq_t state_q
);
    localparam int CW = $clog2(MUTE_FRAMES + 1);
    localparam logic [CW-1:0] LAST = CW'(MUTE_FRAMES - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Next-state logic: evaluated only on a frame-start strobe
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fs_stb) begin
            unique case (state_q)
                SEQ_AUX: if (lock_eff) begin
                    state_d = SEQ_MUTE;
                    cnt_d   = '0;
                end
                SEQ_DEM: if (!lock_eff) begin
                    state_d = SEQ_MUTE;
                    cnt_d   = '0;
                end
                SEQ_MUTE: if (cnt_q == LAST) begin
                    state_d = lock_eff ? SEQ_DEM : SEQ_AUX;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                default: state_d = SEQ_AUX;
            endcase
        end
    end

    // State and mute-frame counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_AUX;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R5
    seq_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_stb |=> $stable(state_q));
    // R3
    no_aux_to_dem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_AUX) |=> (state_q != SEQ_DEM));
    // R4
    no_dem_to_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DEM) |=> (state_q != SEQ_AUX));

endmodule

// File: rtl/route_sel.sv
// Module: route_sel
// Applies the override priority (mute over force-aux over sequencer) at
// frame starts. It registers the selected data bit on each bit strobe.
// Assumes the fs_stb cycle also carries the first bit strobe of the frame.
module route_sel
    import audsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  seq_t state_d,
    input  logic fs_stb,
    input  logic bclk_stb,
    input  logic force_aux,
    input  logic force_mute,
    input  logic demod_bit,
    input  logic aux_bit,
    output logic out_bit
);
    route_t route_q;
    route_t route_new;
    route_t route_d;
    logic   data_sel;

    // Priority resolution for the frame about to start
    always_comb begin
        if (force_mute)                route_new = RT_MUTE;
        else if (force_aux)            route_new = RT_AUX;
        else if (state_d == SEQ_DEM)   route_new = RT_DEM;
        else if (state_d == SEQ_AUX)   route_new = RT_AUX;
        else                           route_new = RT_MUTE;
    end

    // Route in effect this cycle, switching only at a frame start
    always_comb route_d = fs_stb ? route_new : route_q;

    // Data multiplexer for the effective route
    always_comb begin
        unique case (route_d)
            RT_DEM:  data_sel = demod_bit;
            RT_AUX:  data_sel = aux_bit;
            default: data_sel = 1'b0;
        endcase
    end

    // Route holding register, muted out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= RT_MUTE;
        else        route_q <= route_d;
    end

    // Output bit register, loaded on bit strobes only
    always_ff @(posedge clk) begin
        if (!rst_n)        out_bit <= 1'b0;
        else if (bclk_stb) out_bit <= data_sel;
    end

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_stb |=> $stable(out_bit));
    // R7
    mute_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_stb && bclk_stb && force_mute) |=> !out_bit);
    // R5
    route_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_stb |=> $stable(route_q));

endmodule

// File: rtl/err_rpt.sv
// Module: err_rpt
// Registers the error/status flag: high when unlocked or when forced.
// Assumes lock_eff already folds in the loop-enable condition.
module err_rpt (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_eff,
    input  logic force_err,
    output logic err_out
);
    // Error flag register, asserted out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) err_out <= 1'b1;
        else        err_out <= force_err | ~lock_eff;
    end

    // R8
    forced_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_err |=> err_out);
    // R8
    locked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_err && lock_eff) |=> !err_out);

endmodule

// File: rtl/audio_out_selector.sv
// Module: audio_out_selector (top)
// Lock-aware selection between demodulated and auxiliary serial data,
// with a muted gap on every switch and three override bits.
// Assumes all strobes and controls are synchronous to clk.
module audio_out_selector
    import audsel_pkg::*;
#(
    parameter int MUTE_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_on,
    input  logic pll_lock,
    input  logic demod_bit,
    input  logic aux_bit,
    input  logic fs_stb,
    input  logic bclk_stb,
    input  logic force_aux,
    input  logic force_mute,
    input  logic force_err,
    output logic out_bit,
    output logic err_out
);
    logic lock_eff;
    seq_t st_d;
    seq_t st_q;

    // Lock only counts while the recovery loop runs (R9)
    always_comb lock_eff = pll_on & pll_lock;

    lock_seq #(.MUTE_FRAMES(MUTE_FRAMES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_eff (lock_eff),
        .fs_stb   (fs_stb),
        .state_d  (st_d),
        .state_q  (st_q)
    );

    route_sel u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_d    (st_d),
        .fs_stb     (fs_stb),
        .bclk_stb   (bclk_stb),
        .force_aux  (force_aux),
        .force_mute (force_mute),
        .demod_bit  (demod_bit),
        .aux_bit    (aux_bit),
        .out_bit    (out_bit)
    );

    err_rpt u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_eff  (lock_eff),
        .force_err (force_err),
        .err_out   (err_out)
    );

    // R9
    stopped_loop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |=> err_out);

endmodule

// File: tb/test_audio_out_selector.sv
module test_audio_out_selector;
    localparam int MF   = 2;
    localparam int NBIT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_on = 1'b1, pll_lock = 1'b0, demod_bit = 1'b0, aux_bit = 1'b0;
    logic fs_stb = 1'b0, bclk_stb = 1'b0;
    logic force_aux = 1'b0, force_mute = 1'b0, force_err = 1'b0;
    logic out_bit, err_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int fc = 0;
    // reference model: 0 aux, 1 mute, 2 demod
    int m_st = 0;
    int m_cnt = 0;
    int m_dir = 0;   // 3 = entering lock, 4 = leaving lock

    always #5 clk = ~clk;

    audio_out_selector #(.MUTE_FRAMES(MF)) i_audio_out_selector (
        .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .pll_lock(pll_lock),
        .demod_bit(demod_bit), .aux_bit(aux_bit), .fs_stb(fs_stb),
        .bclk_stb(bclk_stb), .force_aux(force_aux), .force_mute(force_mute),
        .force_err(force_err), .out_bit(out_bit), .err_out(err_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b (frame %0d)", req, act, exp, fc);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    // One frame of NBIT bits, each bit two clocks. The lock may change
    // to lk2 at bit chg (chg < 0: no change).
    task automatic frame(input logic lk, input logic pon, input logic fa,
                         input logic fm, input logic fe, input int chg,
                         input logic lk2);
        bit   mlk;
        int   route;   // 0 mute, 1 aux, 2 demod
        string tag;
        logic exp_b;
        logic prev;
        pll_lock = lk; pll_on = pon; force_aux = fa; force_mute = fm; force_err = fe;
        mlk = lk & pon;
        // model step at frame start (R3, R4)
        case (m_st)
            0: if (mlk) begin m_st = 1; m_cnt = 0; m_dir = 3; end
            2: if (!mlk) begin m_st = 1; m_cnt = 0; m_dir = 4; end
            default: if (m_cnt == MF-1) begin m_st = mlk ? 2 : 0; m_cnt = 0; end
                     else m_cnt++;
        endcase
        if (fm)              route = 0;
        else if (fa)         route = 1;
        else if (m_st == 2)  route = 2;
        else if (m_st == 0)  route = 1;
        else                 route = 0;
        if (fm) tag = "R7";
        else if (fa) tag = "R6";
        else if (chg >= 0) tag = "R5";
        else if (!pon) tag = "R9";
        else if (m_st == 1) tag = (m_dir == 3) ? "R3" : "R4";
        else if (m_st == 2) tag = "R1";
        else tag = "R2";
        for (int b = 0; b < NBIT; b++) begin
            if (b == chg) pll_lock = lk2;
            fs_stb = (b == 0);
            bclk_stb = 1'b1;
            demod_bit = ((b + fc) % 3 == 0);
            aux_bit = ((b + fc) % 2 == 1);
            exp_b = (route == 2) ? demod_bit : (route == 1) ? aux_bit : 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(tag, out_bit, exp_b);
            check("R8", err_out, fe | ~(pll_lock & pon));
            prev = out_bit;
            fs_stb = 1'b0;
            bclk_stb = 1'b0;
            demod_bit = ~demod_bit;
            aux_bit = ~aux_bit;
            @(posedge clk);
            @(negedge clk);
            check("R11", out_bit, prev);
        end
        fc++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values
        check("R10", out_bit, 1'b0);
        check("R10", err_out, 1'b1);
        // R10: bit strobes before any frame start leave the output at 0
        for (int k = 0; k < 4; k++) begin
            bclk_stb = 1'b1; aux_bit = 1'b1; demod_bit = 1'b1;
            @(posedge clk); @(negedge clk);
            check("R10", out_bit, 1'b0);
            bclk_stb = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        // R2 steady unlock
        repeat (3) frame(0, 1, 0, 0, 0, -1, 0);
        // R3 then R1
        repeat (5) frame(1, 1, 0, 0, 0, -1, 0);
        // R4 then R2
        repeat (4) frame(0, 1, 0, 0, 0, -1, 0);
        // lock lost during the lock-in mute: back to aux after the gap (R3)
        frame(1, 1, 0, 0, 0, -1, 0);
        repeat (3) frame(0, 1, 0, 0, 0, -1, 0);
        // R6 with lock high and low
        repeat (4) frame(1, 1, 1, 0, 0, -1, 0);
        repeat (2) frame(1, 1, 0, 0, 0, -1, 0);
        repeat (2) frame(0, 1, 1, 0, 0, -1, 0);
        // R7 over force-aux and over locked demod
        repeat (2) frame(0, 1, 1, 1, 0, -1, 0);
        repeat (4) frame(1, 1, 0, 0, 0, -1, 0);
        repeat (2) frame(1, 1, 1, 1, 0, -1, 0);
        repeat (2) frame(1, 1, 0, 1, 1, -1, 0);
        // R8 forced error while locked
        repeat (2) frame(1, 1, 0, 0, 1, -1, 0);
        // R9 loop stopped while lock flag stays high
        repeat (4) frame(1, 0, 0, 0, 0, -1, 0);
        // R5 mid-frame lock rise and fall
        frame(0, 1, 0, 0, 0, 3, 1);
        repeat (4) frame(1, 1, 0, 0, 0, -1, 0);
        frame(1, 1, 0, 0, 0, 5, 0);
        repeat (3) frame(0, 1, 0, 0, 0, -1, 0);
        summary();
    end
endmodule